// File: doc/BRIEF.md
# I/O Space Wait-State Generator

This block runs accesses to a 2048-word peripheral I/O space. Each word is 16 bits wide. The space is reached through its own select strobe. A requester issues one access at a time, made of an 11-bit address, a read/write flag and, for a write, a data word. The block takes bits [10:9] of the address to pick one of four 512-word regions. It loads a down-counter from that region's 3-bit wait register. It then keeps the select and direction strobes asserted until the count runs out.

Completion is shown by a one-cycle done pulse in the last strobe cycle. Read data is captured at the end of that cycle. The four wait registers are loaded through a small configuration port. Every wait register comes out of reset at 7, the slowest timing. A request can only start while the block is idle. While an access is in progress, a busy flag holds the requester off.

Top module: `iows_top`

## Requirements
- R1: After reset, busy, bus_sel, bus_rd, bus_wr and done are 0 and bus_addr is 0. All four wait registers hold 7, so an access made before any configuration write strobes for 8 cycles.
- R2: Request address bits [10:9] select the wait register: 0 covers 0x000–0x1FF, 1 covers 0x200–0x3FF, 2 covers 0x400–0x5FF and 3 covers 0x600–0x7FF.
- R3: An access using wait value N holds bus_sel asserted for exactly N+1 consecutive cycles. done is high only in the last of those cycles, and bus_sel is low in the cycle after done.
- R4: While bus_sel is high, bus_addr[10:0] equals the request address and bus_addr[13:11] is 0. bus_addr stays stable for the whole strobe.
- R5: On a write (req_write=1), bus_wr is high and bus_rd is low for the whole strobe, and bus_dout carries the request write data throughout.
- R6: On a read (req_write=0), bus_rd is high and bus_wr is low for the whole strobe. rd_data takes the value of bus_din seen in the done cycle, is valid from the next cycle, and holds until the next read completes.
- R7: A request (req_valid=1) is accepted only at an edge where busy is 0. busy is high from the cycle after acceptance through the done cycle. A request presented while busy starts no access, and no access starts while req_valid stays low.
- R8: The wait value is latched when the request is accepted. A configuration write during an access changes only later accesses.
- R9: A wait value of 0 gives a single-cycle strobe, with done in that same cycle.
- R10: When cfg_we=1, cfg_wdata[2:0] is written at the clock edge into the wait register indexed by cfg_sel (0 to 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Wait register write enable |
| cfg_sel | input | 2 | Wait register index |
| cfg_wdata | input | 3 | Wait value to store |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | I/O word address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress; new requests are ignored |
| done | output | 1 | Pulse in the last strobe cycle |
| rd_data | output | 16 | Last captured read word |
| bus_addr | output | 14 | External address, upper 3 bits zero |
| bus_sel | output | 1 | I/O select strobe, active high |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_dout | output | 16 | Write data to the bus |
| bus_din | input | 16 | Read data from the bus |

## Verification
Internal faults show up directly as wrong strobe timing at the ports:
- A corrupted down-counter or a wrong region decode makes the strobe one or more cycles too long or too short. The scoreboard catches this in the done cycle of that same access, because it compares the counted strobe length with the wait value it expects for the addressed region.
- A state register that fails to return to idle shows as bus_sel staying high after done, seen one cycle later.
- Losing the latched address, data or direction makes bus_addr, bus_dout or the strobes differ from the queued request on the first wrong strobe cycle.
- A bad read capture makes rd_data differ from the expected word in the cycle after done.

// File: rtl/iows_pkg.sv
// Package: shared sizes and the sequencer state type for the I/O
// wait-state generator. Assumes a 14-bit external bus and an 11-bit I/O space.
package iows_pkg;
    localparam int IO_ADDR_W  = 11;
    localparam int BUS_ADDR_W = 14;
    localparam int IO_DATA_W  = 16;
    localparam int WAIT_W     = 3;
    localparam int N_REGION   = 4;
    localparam int REGION_W   = $clog2(N_REGION);

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STROBE = 1'b1
    } iows_state_e;
endpackage

// File: rtl/iows_regfile.sv
// Module: bank of per-region wait registers.
// Assumes writes are single-cycle and have priority over nothing else.
// Every register resets to its maximum value, the slowest timing.
module iows_regfile #(
    parameter int N_REG  = 4,
    parameter int WAIT_W = 3,
    localparam int SEL_W = $clog2(N_REG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_sel,
    input  logic [WAIT_W-1:0]         cfg_wdata,
    output logic [N_REG*WAIT_W-1:0]   wait_flat
);
    localparam logic [WAIT_W-1:0] RESET_VAL = {WAIT_W{1'b1}};

    genvar gi;
    generate
        for (gi = 0; gi < N_REG; gi++) begin : g_reg
            // Load one wait register when it is addressed by the config port.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    wait_flat[gi*WAIT_W +: WAIT_W] <= RESET_VAL;
                else if (cfg_we && (cfg_sel == SEL_W'(gi)))
                    wait_flat[gi*WAIT_W +: WAIT_W] <= cfg_wdata;
            end
        end
    endgenerate

    // R1: the first cycle out of reset sees every register at its maximum.
    assert_reset_max_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wait_flat == {N_REG{RESET_VAL}}));

    // R10: a config write lands in the addressed register on the next cycle.
    assert_cfg_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == '0) |=> (wait_flat[WAIT_W-1:0] == $past(cfg_wdata)));
endmodule

// File: rtl/iows_decode.sv
// Module: region decoder. The top address bits pick one of the equal-size
// regions, and the matching wait value is muxed out. Purely combinational.
module iows_decode #(
    parameter int ADDR_W = 11,
    parameter int N_REG  = 4,
    parameter int WAIT_W = 3,
    localparam int SEL_W = $clog2(N_REG)
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [N_REG*WAIT_W-1:0]  wait_flat,
    output logic [SEL_W-1:0]         region,
    output logic [WAIT_W-1:0]        wait_sel
);
    // Take the region index from the address MSBs and pick its wait value.
    always_comb begin
        region   = addr[ADDR_W-1 -: SEL_W];
        wait_sel = wait_flat[region*WAIT_W +: WAIT_W];
    end
endmodule

// File: rtl/iows_seq.sv
// Module: access sequencer. It accepts a request only when idle, latches
// address, data, direction and wait count, and drives the strobes for
// count+1 cycles. done is raised in the last cycle, where read data is
// captured. Assumes bus_din is valid in the final strobe cycle.
module iows_seq
    import iows_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int BUS_AW     = 14,
    parameter int DATA_W     = 16,
    parameter int WAIT_W     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [WAIT_W-1:0]  wait_sel,
    input  logic [DATA_W-1:0]  bus_din,
    output logic               busy,
    output logic               done,
    output logic [DATA_W-1:0]  rd_data,
    output logic [BUS_AW-1:0]  bus_addr,
    output logic               bus_sel,
    output logic               bus_rd,
    output logic               bus_wr,
    output logic [DATA_W-1:0]  bus_dout
);
    iows_state_e         state;
    logic [WAIT_W-1:0]   cnt;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                write_q;
    logic                active;
    logic                last;

    // Decode the current phase of the access.
    always_comb begin
        active = (state == ST_STROBE);
        last   = active && (cnt == '0);
    end

    // Step the state and count; latch the request when accepting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state   <= ST_STROBE;
                        cnt     <= wait_sel;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        write_q <= req_write;
                    end
                end
                default: begin
                    if (cnt == '0)
                        state <= ST_IDLE;
                    else
                        cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    // Capture the read word at the end of the final strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (last && !write_q)
            rd_data <= bus_din;
    end

    // Drive the bus strobes, address and write data from the latched request.
    always_comb begin
        busy     = active;
        done     = last;
        bus_sel  = active;
        bus_rd   = active && !write_q;
        bus_wr   = active && write_q;
        bus_addr = active ? {{(BUS_AW-ADDR_W){1'b0}}, addr_q} : '0;
        bus_dout = (active && write_q) ? wdata_q : '0;
    end

    // R3: done only ever appears inside a strobe.
    assert_done_in_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bus_sel);

    // R3: the strobe drops in the cycle right after done.
    assert_strobe_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !bus_sel);

    // R8: the latched count falls by one each non-final strobe cycle.
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt != '0) |=> (active && cnt == $past(cnt) - 1'b1));

    // R4: the address does not move within an access.
    assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !done) |=> $stable(bus_addr));

    // R5: the read and write strobes are never high together.
    assert_rw_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R7: with no request while idle, no strobe starts.
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> !bus_sel);
endmodule

// File: rtl/iows_top.sv
// Module: top of the I/O wait-state generator. Ties the wait register bank,
// the region decoder and the access sequencer together.
// Assumes one requester and a synchronous peripheral bus.
module iows_top
    import iows_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [REGION_W-1:0]    cfg_sel,
    input  logic [WAIT_W-1:0]      cfg_wdata,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [IO_ADDR_W-1:0]   req_addr,
    input  logic [IO_DATA_W-1:0]   req_wdata,
    output logic                   busy,
    output logic                   done,
    output logic [IO_DATA_W-1:0]   rd_data,
    output logic [BUS_ADDR_W-1:0]  bus_addr,
    output logic                   bus_sel,
    output logic                   bus_rd,
    output logic                   bus_wr,
    output logic [IO_DATA_W-1:0]   bus_dout,
    input  logic [IO_DATA_W-1:0]   bus_din
);
    logic [N_REGION*WAIT_W-1:0] wait_flat;
    logic [REGION_W-1:0]        region;
    logic [WAIT_W-1:0]          wait_sel;

    iows_regfile #(.N_REG(N_REGION), .WAIT_W(WAIT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .wait_flat (wait_flat)
    );

    iows_decode #(.ADDR_W(IO_ADDR_W), .N_REG(N_REGION), .WAIT_W(WAIT_W)) u_dec (
        .addr      (req_addr),
        .wait_flat (wait_flat),
        .region    (region),
        .wait_sel  (wait_sel)
    );

    iows_seq #(.ADDR_W(IO_ADDR_W), .BUS_AW(BUS_ADDR_W),
               .DATA_W(IO_DATA_W), .WAIT_W(WAIT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .wait_sel  (wait_sel),
        .bus_din   (bus_din),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .bus_addr  (bus_addr),
        .bus_sel   (bus_sel),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_dout  (bus_dout)
    );

    // R2: region index matches the address MSBs on any request.
    assert_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (region == req_addr[IO_ADDR_W-1 -: REGION_W]));
endmodule

// File: tb/sim_iows_top.sv
// Bench: scoreboard for iows_top. The driver queues expected accesses; the
// monitor checks every strobe cycle, the strobe length and the read capture.
module sim_iows_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        wr;
        logic [10:0] addr;
        logic [15:0] data;
        int          waits;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [2:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, bus_sel, bus_rd, bus_wr;
    logic [15:0] rd_data, bus_dout, bus_din;
    logic [13:0] bus_addr;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    int    mdl_wait [4];
    item_t exp_q [$];
    int    cyc = 0;
    bit    pend_rd = 1'b0;
    logic [15:0] pend_val = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_din = {5'b0, bus_addr[10:0]} ^ 16'hA5C3;

    iows_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .bus_addr(bus_addr), .bus_sel(bus_sel),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_dout(bus_dout), .bus_din(bus_din)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 3'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        mdl_wait[sel] = val;
    endtask

    // Wait for idle, issue one request, queue its expectation.
    task automatic do_access(input bit wr, input int addr, input int data);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        it.wr = wr; it.addr = 11'(addr); it.data = 16'(data);
        it.waits = mdl_wait[addr[10:9]];
        exp_q.push_back(it);
        req_valid = 1'b1; req_write = wr; req_addr = 11'(addr); req_wdata = 16'(data);
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    endtask

    // Present a request while busy; it must not start an access.
    task automatic poke_busy(input int addr);
        check(busy == 1'b1, "R7 poke while busy", int'(busy), 1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 11'(addr); req_wdata = 16'hDEAD;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        while (busy || exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare each strobe cycle and each completion to the queue head.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (pend_rd) begin
                check(rd_data == pend_val, "R6 read capture", int'(rd_data), int'(pend_val));
                pend_rd = 1'b0;
            end
            if (bus_sel) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected access", int'(bus_addr), 0);
                end else begin
                    cyc++;
                    check(bus_addr == {3'b000, exp_q[0].addr}, "R4 bus address",
                          int'(bus_addr), int'({3'b000, exp_q[0].addr}));
                    check(bus_wr == exp_q[0].wr && bus_rd == !exp_q[0].wr, "R5/R6 strobes",
                          int'({bus_rd, bus_wr}), int'({!exp_q[0].wr, exp_q[0].wr}));
                    if (exp_q[0].wr)
                        check(bus_dout == exp_q[0].data, "R5 write data",
                              int'(bus_dout), int'(exp_q[0].data));
                    if (done) begin
                        if (exp_q[0].waits == 0)
                            check(cyc == 1, "R9 zero-wait length", cyc, 1);
                        check(cyc == exp_q[0].waits + 1, "R3/R2/R8 strobe length",
                              cyc, exp_q[0].waits + 1);
                        if (!exp_q[0].wr) begin
                            pend_rd = 1'b1;
                            pend_val = {5'b0, exp_q[0].addr} ^ 16'hA5C3;
                        end
                        void'(exp_q.pop_front());
                        cyc = 0;
                    end
                end
            end else begin
                check(done == 1'b0, "R3 done outside strobe", int'(done), 0);
                if (cyc != 0)
                    check(1'b0, "R3 strobe dropped before done", cyc, 0);
                cyc = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) mdl_wait[i] = 7;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset.
        check(!busy && !bus_sel && !bus_rd && !bus_wr && !done, "R1 idle outputs",
              int'({busy, bus_sel, bus_rd, bus_wr, done}), 0);
        check(bus_addr == '0, "R1 bus address zero", int'(bus_addr), 0);
        // R1: default waits of 7 in every region.
        do_access(1'b1, 11'h000, 16'h1234);
        do_access(1'b0, 11'h3FF, 0);
        do_access(1'b1, 11'h400, 16'hBEEF);
        do_access(1'b0, 11'h7FF, 0);
        drain();
        // R10 and R2: distinct waits per region, boundaries.
        cfg_write(0, 1);
        cfg_write(1, 3);
        cfg_write(2, 0);
        cfg_write(3, 5);
        do_access(1'b0, 11'h1FF, 0);
        do_access(1'b0, 11'h200, 0);
        do_access(1'b1, 11'h5FF, 16'h0F0F);
        do_access(1'b0, 11'h400, 0);
        do_access(1'b1, 11'h600, 16'hA5A5);
        do_access(1'b0, 11'h7FF, 0);
        drain();
        // R9: zero wait in region 0, back-to-back.
        cfg_write(0, 0);
        do_access(1'b1, 11'h010, 16'h0001);
        do_access(1'b0, 11'h020, 0);
        drain();
        // R8: reconfigure region 1 mid-access; current access keeps old count.
        cfg_write(1, 2);
        do_access(1'b0, 11'h2AA, 0);
        cfg_write(1, 6);
        drain();
        do_access(1'b0, 11'h2AB, 0);
        drain();
        // R7: request while busy is ignored; nothing starts afterwards.
        cfg_write(3, 4);
        do_access(1'b1, 11'h655, 16'h7777);
        poke_busy(11'h123);
        drain();
        repeat (2) begin
            @(negedge clk);
            check(!bus_sel, "R7 no access after ignored request", int'(bus_sel), 0);
        end
        // R6: rd_data holds across a write.
        do_access(1'b0, 11'h0AB, 0);
        drain();
        do_access(1'b1, 11'h0CD, 16'h4321);
        drain();
        check(rd_data == ({5'b0, 11'h0AB} ^ 16'hA5C3), "R6 read data held",
              int'(rd_data), int'({5'b0, 11'h0AB} ^ 16'hA5C3));
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule